// File: doc/BRIEF.md
# Serial-Wire Debug Transfer Engine

This block carries out a single register transfer of the two-wire serial debug protocol. It works at the level of individual bits. The transfer is started by a one-cycle strobe. The block then sends an eight-bit header onto the data line. It releases the line for the target's acknowledge, and either drives or samples a 32-bit word with parity. It closes with a per-transfer number of low idle clock periods. The outcome is reported as a three-bit status code, and read data goes out on a 32-bit output.

The debug clock is made from the system clock by a divider set by a parameter. Each bit slot opens with the debug clock low. The line changes only at the falling edge that opens a slot, and input bits are captured at the rising edge in the middle of the slot. If the acknowledge is anything other than OK, the data phase is skipped: the line stays released for one turnaround slot and then returns to host drive. Retries, line resets and protocol switching are left to the logic that issues requests.

Top module: `swire_xfer_engine`

## Requirements
- R1: The header goes out in slots 0 to 7 with the line driven, in this order: 1, port select (1 = access port), read flag (1 = read), address bit A2 (`req_addr[0]`), address bit A3 (`req_addr[1]`), the XOR of the four previous fields, 0, 1.
- R2: Slot 8 is a turnaround and slots 9 to 11 carry the acknowledge. The line output enable is low in all of them and also in slot 12, whatever the outcome.
- R3: The acknowledge bits, listed in the order sampled, decode to a status: 1,0,0 gives 0 (OK); 0,1,0 gives 1 (WAIT); 0,0,1 gives 2 (FAULT); 1,1,1 gives 3 (no response); any other pattern gives 4 (protocol error).
- R4: On a write with an OK acknowledge, slot 12 is a released turnaround. Slots 13 to 44 drive the write word, least significant bit first. Slot 45 drives a parity bit that is 1 when the word has an odd number of ones.
- R5: On a read with an OK acknowledge, slots 12 to 43 sample the word least significant bit first, slot 44 samples parity and slot 45 is a turnaround, all with the line released. A parity mismatch gives status 5. `rdata` is updated only by a read that ends with status 0.
- R6: If the acknowledge is not OK, the transfer holds 13 slots plus the idle count, and no data or parity slot takes place.
- R7: After the last protocol slot, the block drives `req_idle` slots with the line enabled and low. An OK transfer holds 46 slots plus the idle count.
- R8: The debug clock is low when no transfer runs. Its period is 2·DIV_HALF system cycles. Line output and enable never change while it is high.
- R9: `busy` is high from the cycle after an accepted start until completion. `done` is a single-cycle pulse that comes with the new status. A start while busy is ignored. After reset `busy`, `done`, `status` and `rdata` are zero and the line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only while idle |
| req_ap | input | 1 | 1 selects the access port, 0 the debug port |
| req_rd | input | 1 | 1 for a read, 0 for a write |
| req_addr | input | 2 | Register address bits {A3, A2} |
| req_wdata | input | 32 | Word to write |
| req_idle | input | IDLE_W | Number of trailing idle slots |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Outcome code of the last transfer |
| rdata | output | 32 | Word from the last successful read |
| line_clk | output | 1 | Debug clock |
| line_out | output | 1 | Data line value when driven |
| line_oe | output | 1 | Data line output enable |
| line_in | input | 1 | Data line value as seen from the pin |

## Verification
Two things can meet in the same system cycle: a new start strobe and the sequencer stepping on a falling debug-clock edge of a transfer already under way. The bench raises start, with a different request on the inputs, in the middle of a read. The transfer counts as undisturbed when its slot count, header, release pattern, status and read word all match a read run with no interference. A target model answers with each acknowledge class and with a corrupted parity bit. This tests the short path after a non-OK acknowledge and confirms that the stored read word survives a failed read.

// File: rtl/swire_pkg.sv
package swire_pkg;

    localparam int DATA_W = 32;
    localparam int HDR_W  = 8;
    localparam int ACK_W  = 3;

    typedef enum logic [2:0] {
        ST_OK     = 3'd0,
        ST_WAIT   = 3'd1,
        ST_FAULT  = 3'd2,
        ST_NORESP = 3'd3,
        ST_PROTO  = 3'd4,
        ST_PARITY = 3'd5
    } xfer_status_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_REQ,
        PH_TRN_A,
        PH_ACK,
        PH_TRN_W,
        PH_WDATA,
        PH_WPAR,
        PH_RDATA,
        PH_RPAR,
        PH_TRN_R,
        PH_TRN_E,
        PH_PAD
    } phase_e;

    typedef struct packed {
        logic              ap;
        logic [1:0]        addr;   // {A3, A2}
        logic [DATA_W-1:0] wdata;
    } xfer_req_t;

    // Header bits, index 0 leaves the block first.
    function automatic logic [HDR_W-1:0] build_header(input xfer_req_t r, input logic rd);
        logic par;
        par = r.ap ^ rd ^ r.addr[0] ^ r.addr[1];
        return {1'b1, 1'b0, par, r.addr[1], r.addr[0], rd, r.ap, 1'b1};
    endfunction

    // a[0] is the bit sampled first.
    function automatic xfer_status_e decode_ack(input logic [ACK_W-1:0] a);
        case (a)
            3'b001:  return ST_OK;
            3'b010:  return ST_WAIT;
            3'b100:  return ST_FAULT;
            3'b111:  return ST_NORESP;
            default: return ST_PROTO;
        endcase
    endfunction

endpackage

// File: rtl/swire_clkgen.sv
module swire_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic swclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          edge_w;

    assign edge_w    = run && (cnt_q == LAST);
    assign rise_tick = edge_w && !swclk;
    assign fall_tick = edge_w && swclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            swclk <= 1'b0;
        end else if (edge_w) begin
            cnt_q <= '0;
            swclk <= ~swclk;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_CLK_PARKED_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> !swclk); // R8

endmodule

// File: rtl/swire_sequencer.sv
module swire_sequencer
    import swire_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_rd,
    input  logic [IDLE_W-1:0] req_idle,
    input  logic              fall_tick,
    input  logic              ack_ok,
    output phase_e            phase_q,
    output phase_e            phase_d,
    output logic [4:0]        bidx_q,
    output logic [4:0]        bidx_d,
    output logic              xfer_rd,
    output logic              load,
    output logic              step,
    output logic              fin,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam int PW = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDLE_W-1:0] idle_q;
    logic              adv;
    logic              pad_last;
    phase_e            tail_ph;

    assign busy     = (phase_q != PH_IDLE);
    assign load     = start && !busy;
    assign adv      = fall_tick && busy;
    assign step     = load || adv;
    assign fin      = adv && (phase_d == PH_IDLE);
    assign bidx_q   = cnt_q[4:0];
    assign bidx_d   = cnt_d[4:0];
    assign pad_last = ((PW'(cnt_q) + PW'(1)) == PW'(idle_q));
    assign tail_ph  = (idle_q == '0) ? PH_IDLE : PH_PAD;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (load) begin
            phase_d = PH_REQ;
            cnt_d   = '0;
        end else if (adv) begin
            cnt_d = cnt_q + CNT_W'(1);
            case (phase_q)
                PH_REQ: if (cnt_q == HDR_LAST) begin
                    phase_d = PH_TRN_A;
                    cnt_d   = '0;
                end
                PH_TRN_A: begin
                    phase_d = PH_ACK;
                    cnt_d   = '0;
                end
                PH_ACK: if (cnt_q == ACK_LAST) begin
                    cnt_d   = '0;
                    phase_d = !ack_ok ? PH_TRN_E : (xfer_rd ? PH_RDATA : PH_TRN_W);
                end
                PH_TRN_W: begin
                    phase_d = PH_WDATA;
                    cnt_d   = '0;
                end
                PH_WDATA: if (cnt_q == DATA_LAST) begin
                    phase_d = PH_WPAR;
                    cnt_d   = '0;
                end
                PH_RDATA: if (cnt_q == DATA_LAST) begin
                    phase_d = PH_RPAR;
                    cnt_d   = '0;
                end
                PH_RPAR: begin
                    phase_d = PH_TRN_R;
                    cnt_d   = '0;
                end
                PH_WPAR, PH_TRN_R, PH_TRN_E: begin
                    phase_d = tail_ph;
                    cnt_d   = '0;
                end
                PH_PAD: if (pad_last) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            xfer_rd <= 1'b0;
            idle_q  <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done    <= fin;
            if (load) begin
                xfer_rd <= req_rd;
                idle_q  <= req_idle;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_REQ) |=> (phase_q != PH_REQ)); // R9

    AST_SHORT_PATH: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRN_E) |=> (phase_q inside {PH_TRN_E, PH_PAD, PH_IDLE})); // R6

endmodule

// File: rtl/swire_datapath.sv
module swire_datapath
    import swire_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic               fin,
    input  logic               rise_tick,
    input  xfer_req_t          req,
    input  logic               req_rd,
    input  logic               xfer_rd,
    input  phase_e             phase_q,
    input  phase_e             phase_d,
    input  logic [4:0]         bidx_q,
    input  logic [4:0]         bidx_d,
    input  logic               line_in,
    output logic               line_out,
    output logic               line_oe,
    output logic               ack_ok,
    output xfer_status_e       status,
    output logic [DATA_W-1:0]  rdata
);
    logic [HDR_W-1:0]  hdr_now, hdr_q;
    logic [DATA_W-1:0] wdata_q, rsh_q;
    logic [ACK_W-1:0]  ack_q;
    logic              rpar_q;
    xfer_status_e      st_q;
    logic              drv_oe, drv_bit;

    assign hdr_now = build_header(req, req_rd);
    assign ack_ok  = (decode_ack(ack_q) == ST_OK);

    // Line state for the slot that opens at this step.
    always_comb begin
        drv_oe  = 1'b0;
        drv_bit = 1'b0;
        if (load) begin
            drv_oe  = 1'b1;
            drv_bit = hdr_now[0];
        end else begin
            case (phase_d)
                PH_REQ: begin
                    drv_oe  = 1'b1;
                    drv_bit = hdr_q[bidx_d[2:0]];
                end
                PH_WDATA: begin
                    drv_oe  = 1'b1;
                    drv_bit = wdata_q[bidx_d];
                end
                PH_WPAR: begin
                    drv_oe  = 1'b1;
                    drv_bit = ^wdata_q;
                end
                PH_IDLE, PH_PAD: begin
                    drv_oe  = 1'b1;
                    drv_bit = 1'b0;
                end
                default: begin
                    drv_oe  = 1'b0;
                    drv_bit = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q    <= '0;
            wdata_q  <= '0;
            rsh_q    <= '0;
            ack_q    <= '0;
            rpar_q   <= 1'b0;
            st_q     <= ST_OK;
            line_oe  <= 1'b1;
            line_out <= 1'b0;
            status   <= ST_OK;
            rdata    <= '0;
        end else begin
            if (load) begin
                hdr_q   <= hdr_now;
                wdata_q <= req.wdata;
                ack_q   <= '0;
                st_q    <= ST_OK;
            end
            if (rise_tick) begin
                case (phase_q)
                    PH_ACK: case (bidx_q[1:0])
                        2'd0:    ack_q[0] <= line_in;
                        2'd1:    ack_q[1] <= line_in;
                        default: ack_q[2] <= line_in;
                    endcase
                    PH_RDATA: rsh_q[bidx_q] <= line_in;
                    PH_RPAR:  rpar_q <= line_in;
                    default: ;
                endcase
            end
            if (step) begin
                line_oe  <= drv_oe;
                line_out <= drv_bit;
                if (phase_q == PH_ACK && phase_d != PH_ACK)
                    st_q <= decode_ack(ack_q);
                if (phase_q == PH_RPAR && ((^rsh_q) != rpar_q))
                    st_q <= ST_PARITY;
            end
            if (fin) begin
                status <= st_q;
                if (xfer_rd && st_q == ST_OK)
                    rdata <= rsh_q;
            end
        end
    end

    AST_TRN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase_q inside {PH_TRN_A, PH_ACK}) |-> !line_oe); // R2

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase_q inside {PH_RDATA, PH_RPAR, PH_TRN_R}) |-> !line_oe); // R5

    AST_PAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PAD) |-> (line_oe && !line_out)); // R7

endmodule

// File: rtl/swire_xfer_engine.sv
module swire_xfer_engine
    import swire_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int IDLE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_ap,
    input  logic              req_rd,
    input  logic [1:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [IDLE_W-1:0] req_idle,
    output logic              busy,
    output logic              done,
    output logic [2:0]        status,
    output logic [31:0]       rdata,
    output logic              line_clk,
    output logic              line_out,
    output logic              line_oe,
    input  logic              line_in
);
    localparam int CNT_W = (IDLE_W > 5) ? IDLE_W : 5;

    xfer_req_t    req_w;
    phase_e       phase_q, phase_d;
    logic [4:0]   bidx_q, bidx_d;
    logic         xfer_rd, load, step, fin, ack_ok;
    logic         rise_tick, fall_tick;
    xfer_status_e status_w;

    assign req_w  = '{ap: req_ap, addr: req_addr, wdata: req_wdata};
    assign status = status_w;

    swire_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .swclk     (line_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    swire_sequencer #(.IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_rd    (req_rd),
        .req_idle  (req_idle),
        .fall_tick (fall_tick),
        .ack_ok    (ack_ok),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .bidx_q    (bidx_q),
        .bidx_d    (bidx_d),
        .xfer_rd   (xfer_rd),
        .load      (load),
        .step      (step),
        .fin       (fin),
        .busy      (busy),
        .done      (done)
    );

    swire_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .fin       (fin),
        .rise_tick (rise_tick),
        .req       (req_w),
        .req_rd    (req_rd),
        .xfer_rd   (xfer_rd),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .bidx_q    (bidx_q),
        .bidx_d    (bidx_d),
        .line_in   (line_in),
        .line_out  (line_out),
        .line_oe   (line_oe),
        .ack_ok    (ack_ok),
        .status    (status_w),
        .rdata     (rdata)
    );

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (line_clk && $past(line_clk)) |-> ($stable(line_out) && $stable(line_oe))); // R8

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (status <= 3'd5)); // R3

endmodule

// File: tb/swire_xfer_engine_bench.sv
module swire_xfer_engine_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV    = 2;
    localparam int IDLE_W = 8;
    localparam int NSLOT  = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              req_ap = 1'b0;
    logic              req_rd = 1'b0;
    logic [1:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [IDLE_W-1:0] req_idle = '0;
    logic              line_in = 1'b0;
    logic              busy, done, line_clk, line_out, line_oe;
    logic [2:0]        status;
    logic [31:0]       rdata;

    int     checks = 0;
    int     errors = 0;
    logic   resp_bits [NSLOT];
    logic   host_bit  [NSLOT];
    logic   host_oe   [NSLOT];
    int     tslot = 0;
    int     rises = 0;
    longint cyc = 0;
    longint last_rise = 0;
    longint gap_min = 0;
    longint gap_max = 0;
    logic [31:0] exp_rdata = '0;

    swire_xfer_engine #(.DIV_HALF(DIV), .IDLE_W(IDLE_W)) u_swire_xfer_engine (
        .clk (clk), .rst (rst), .start (start), .req_ap (req_ap), .req_rd (req_rd),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_idle (req_idle),
        .busy (busy), .done (done), .status (status), .rdata (rdata),
        .line_clk (line_clk), .line_out (line_out), .line_oe (line_oe), .line_in (line_in)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    // Target model: logs host slots at the rising edge, presents its bit after the falling edge.
    always @(posedge line_clk) begin
        if (tslot < NSLOT) begin
            host_bit[tslot] = line_out;
            host_oe[tslot]  = line_oe;
        end
        if (rises > 0) begin
            if (cyc - last_rise < gap_min) gap_min = cyc - last_rise;
            if (cyc - last_rise > gap_max) gap_max = cyc - last_rise;
        end
        last_rise = cyc;
        rises = rises + 1;
    end

    always @(negedge line_clk) begin
        tslot = tslot + 1;
        line_in = (tslot < NSLOT) ? resp_bits[tslot] : 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ack: bit 0 is the first sampled acknowledge bit.
    task automatic run_xfer(input bit ap, input bit rd, input logic [1:0] a, input logic [31:0] wd,
                            input int idle, input logic [2:0] ack, input logic [31:0] td,
                            input bit badpar, input bit poke);
        int n, bad, base, exp_slots;
        bit ok;
        logic [2:0]  exp_st;
        logic [7:0]  hw, hexp;
        logic [31:0] dw;
        for (int i = 0; i < NSLOT; i++) begin
            resp_bits[i] = 1'b0;
            host_bit[i]  = 1'b0;
            host_oe[i]   = 1'b0;
        end
        for (int k = 0; k < 3; k++) resp_bits[9 + k] = ack[k];
        if (rd) begin
            for (int i = 0; i < 32; i++) resp_bits[12 + i] = td[i];
            resp_bits[44] = (^td) ^ badpar;
        end
        tslot = 0; rises = 0; gap_min = 1000000; gap_max = 0;
        line_in = resp_bits[0];
        @(negedge clk);
        req_ap = ap; req_rd = rd; req_addr = a; req_wdata = wd; req_idle = IDLE_W'(idle);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            req_rd = ~rd; req_wdata = ~wd; req_ap = ~ap; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            chk(0, "R9 done never seen", 0, 1);
            return;
        end
        ok = (ack == 3'b001);
        case (ack)
            3'b001:  exp_st = 3'd0;
            3'b010:  exp_st = 3'd1;
            3'b100:  exp_st = 3'd2;
            3'b111:  exp_st = 3'd3;
            default: exp_st = 3'd4;
        endcase
        if (ok && rd && badpar) exp_st = 3'd5;
        chk(status == exp_st, "R3 R5 status code", status, exp_st);
        if (rd && exp_st == 3'd0) exp_rdata = td;
        chk(rdata == exp_rdata, "R5 read word", rdata, exp_rdata);
        exp_slots = (ok ? 46 : 13) + idle;
        chk(rises == exp_slots, "R6 R7 slot count", rises, exp_slots);
        hexp = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            hw[i] = host_bit[i];
            if (!host_oe[i]) bad++;
        end
        chk(hw == hexp && bad == 0, "R1 header", {hw, 8'(bad)}, {hexp, 8'd0});
        bad = 0;
        for (int i = 8; i <= 12; i++) if (host_oe[i]) bad++;
        chk(bad == 0, "R2 released slots 8..12", bad, 0);
        if (ok && !rd) begin
            bad = 0;
            for (int i = 0; i < 32; i++) begin
                dw[i] = host_bit[13 + i];
                if (!host_oe[13 + i]) bad++;
            end
            if (!host_oe[45]) bad++;
            chk(dw == wd && bad == 0, "R4 write word", dw, wd);
            chk(host_bit[45] == ^wd, "R4 write parity", host_bit[45], ^wd);
        end
        if (ok && rd) begin
            bad = 0;
            for (int i = 12; i <= 45; i++) if (host_oe[i]) bad++;
            chk(bad == 0, "R5 released read slots", bad, 0);
        end
        base = ok ? 46 : 13;
        bad = 0;
        for (int i = base; i < base + idle; i++) if (!host_oe[i] || host_bit[i]) bad++;
        chk(bad == 0, "R7 idle slots low", bad, 0);
        chk(gap_min == 2 * DIV && gap_max == 2 * DIV, "R8 clock period",
            {gap_min[31:0], gap_max[31:0]}, {32'(2 * DIV), 32'(2 * DIV)});
        @(negedge clk);
        chk(!done && !busy && !line_clk, "R9 R8 done pulse, clock parked",
            {done, busy, line_clk}, 3'b000);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !line_clk, "R9 reset control", {busy, done, line_clk}, 3'b000);
        chk(line_oe && !line_out, "R9 reset line driven low", {line_oe, line_out}, 2'b10);
        chk(status == 3'd0 && rdata == 32'd0, "R9 reset results", {status, rdata}, 0);
        // write, access port, A3:A2 = 01, OK
        run_xfer(1'b1, 1'b0, 2'b01, 32'hC0FFEE15, 2, 3'b001, 32'h0, 1'b0, 1'b0);
        // read, debug port, A3:A2 = 11, OK, no idle
        run_xfer(1'b0, 1'b1, 2'b11, 32'h0, 0, 3'b001, 32'hA5C30F01, 1'b0, 1'b0);
        // read with a corrupted parity bit: status 5, word kept
        run_xfer(1'b1, 1'b1, 2'b10, 32'h0, 1, 3'b001, 32'h12345678, 1'b1, 1'b0);
        // WAIT on a write (sampled 0,1,0)
        run_xfer(1'b1, 1'b0, 2'b00, 32'h5555AAAA, 3, 3'b010, 32'h0, 1'b0, 1'b0);
        // FAULT on a read (sampled 0,0,1)
        run_xfer(1'b1, 1'b1, 2'b01, 32'h0, 0, 3'b100, 32'hDEADBEEF, 1'b0, 1'b0);
        // no response (1,1,1)
        run_xfer(1'b0, 1'b1, 2'b00, 32'h0, 2, 3'b111, 32'hFFFFFFFF, 1'b0, 1'b0);
        // invalid pattern (sampled 0,1,1)
        run_xfer(1'b0, 1'b0, 2'b10, 32'h1, 0, 3'b110, 32'h0, 1'b0, 1'b0);
        // start raised mid-read is ignored
        run_xfer(1'b1, 1'b1, 2'b00, 32'h0, 4, 3'b001, 32'h00000001, 1'b0, 1'b1);
        // all-ones write word, even parity
        run_xfer(1'b0, 1'b0, 2'b10, 32'hFFFFFFFF, 1, 3'b001, 32'h0, 1'b0, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule